// File: doc/BRIEF.md
# Debug Link Mode-Switch Sequence Generator

This block drives the fixed bit patterns that a debug probe places on the shared data/mode line of a serial debug port to reset the wire protocol or move a dual-mode port between JTAG, the two-wire serial protocol (SWD) and a low-power dormant state. The user places a sequence number on `pick` and pulses `go`. From the next cycle the block drives one pattern bit per clock on `line_out`, with `line_oe` high. It keeps driving for exactly the length of the chosen pattern and then raises `done` for one cycle.

Each pattern is stored as a short list of segments. A segment is either a run of ones, a run of zeros, or a slice of a fixed code word. This keeps the storage small: the longest pattern, 224 bits, needs seven segments. Every code word leaves the block least-significant bit first, and its lowest byte goes out first.

Top module: `dlsw_gen`

## Requirements
- R1: With `busy` low, a `go` pulse with `pick` in 0..6 is accepted. On the following cycle `busy` and `line_oe` are high and `line_out` carries bit 0 of the pattern. Code words are sent LSB first.
- R2: `pick`=0 (line reset) sends 56 ones and then 8 zeros, 64 bits in all.
- R3: `pick`=1 (JTAG to SWD) sends 56 ones, the 16-bit word 0xE79E, 56 ones and 8 zeros, 136 bits in all.
- R4: `pick`=2 (SWD to JTAG) sends 56 ones, the 16-bit word 0xE73C and 8 ones, 80 bits in all.
- R5: `pick`=3 (SWD to dormant) sends 56 ones and then the 16-bit word 0xE3BC, 72 bits in all.
- R6: `pick`=4 (dormant to SWD) sends 8 ones, the 128-bit alert pattern (bytes 0x92 first through 0x19 last), 4 zeros, the 8-bit word 0x1A, 12 ones, 56 ones and 8 zeros, 224 bits in all.
- R7: `pick`=5 (JTAG to dormant) sends 9 ones and then the 31-bit word 0x33BBBBBA, 40 bits in all.
- R8: `pick`=6 (dormant to JTAG) sends 8 ones, the 128-bit alert pattern and 24 zeros, 160 bits in all.
- R9: `busy` and `line_oe` stay high for exactly the pattern length. A `go` that arrives while `busy` is high changes neither the bits nor the length.
- R10: On the cycle after the last bit, `done` is high for exactly one cycle, `busy` and `line_oe` are low, and `line_out` sits at `IDLE_LVL`. While the block is idle it keeps that quiet state.
- R11: A `go` with `pick`=7 is ignored: `busy` and `line_oe` stay low.
- R12: A `go` given in the cycle in which `done` is high is accepted, so patterns can run back to back with no gap cycle.
- R13: After reset, `busy`, `done` and `line_oe` are low and `line_out` equals `IDLE_LVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one pattern bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, sampled when idle |
| pick | input | 3 | Sequence number 0..6; 7 is reserved |
| busy | output | 1 | High while pattern bits are being driven |
| done | output | 1 | One-cycle pulse after the last bit |
| line_oe | output | 1 | Drive enable for the data line |
| line_out | output | 1 | Serial pattern bit |

## Verification
The finish of one pattern (the `done` pulse, with `busy` dropping) and the acceptance of the next request can happen in the same cycle. The bench provokes this by raising `go` with a new `pick` at the moment `done` is sampled high. It then requires that the very next cycle shows `done` low, `busy` high and the first bit of the new pattern, with no idle gap. Separately, a `go` given in the middle of a running pattern must leave both the bit stream and its length unchanged.

// File: rtl/dlsw_pkg.sv
package dlsw_pkg;

  localparam int unsigned LEN_W  = 8;  // longest single segment is 128 bits
  localparam int unsigned SEG_W  = 3;  // up to 8 segments per pattern
  localparam int unsigned WORD_W = 128;

  typedef enum logic [2:0] {
    SEQ_LINE_RST = 3'd0,
    SEQ_J2S      = 3'd1,
    SEQ_S2J      = 3'd2,
    SEQ_S2D      = 3'd3,
    SEQ_D2S      = 3'd4,
    SEQ_J2D      = 3'd5,
    SEQ_D2J      = 3'd6,
    SEQ_NONE     = 3'd7
  } seq_e;

  typedef enum logic [1:0] {
    RUN_HI   = 2'd0,
    RUN_LO   = 2'd1,
    RUN_CODE = 2'd2
  } run_e;

  typedef enum logic [2:0] {
    CW_J2S   = 3'd0,
    CW_S2J   = 3'd1,
    CW_S2D   = 3'd2,
    CW_ALERT = 3'd3,
    CW_ACT   = 3'd4,
    CW_J2D   = 3'd5
  } code_e;

  typedef struct packed {
    run_e             kind;
    code_e            code;
    logic [LEN_W-1:0] len;
    logic             last;
  } seg_t;

  // Code words, bit 0 leaves first
  localparam logic [15:0]       WORD_J2S   = 16'hE79E;
  localparam logic [15:0]       WORD_S2J   = 16'hE73C;
  localparam logic [15:0]       WORD_S2D   = 16'hE3BC;
  localparam logic [7:0]        WORD_ACT   = 8'h1A;
  localparam logic [30:0]       WORD_J2D   = 31'h33BBBBBA;
  localparam logic [WORD_W-1:0] WORD_ALERT =
    128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;

  function automatic seg_t mk_seg(run_e k, code_e c, int unsigned n, logic l);
    seg_t s;
    s.kind = k;
    s.code = c;
    s.len  = LEN_W'(n);
    s.last = l;
    return s;
  endfunction

endpackage

// File: rtl/dlsw_seg_table.sv
module dlsw_seg_table
  import dlsw_pkg::*;
(
  input  seq_e             seq,
  input  logic [SEG_W-1:0] idx,
  output seg_t             seg
);

  always_comb begin
    seg = mk_seg(RUN_LO, CW_J2S, 1, 1'b1);
    unique case (seq)
      SEQ_LINE_RST: case (idx)
        3'd0:    seg = mk_seg(RUN_HI, CW_J2S, 56, 1'b0);
        default: seg = mk_seg(RUN_LO, CW_J2S, 8, 1'b1);
      endcase
      SEQ_J2S: case (idx)
        3'd0:    seg = mk_seg(RUN_HI,   CW_J2S, 56, 1'b0);
        3'd1:    seg = mk_seg(RUN_CODE, CW_J2S, 16, 1'b0);
        3'd2:    seg = mk_seg(RUN_HI,   CW_J2S, 56, 1'b0);
        default: seg = mk_seg(RUN_LO,   CW_J2S, 8,  1'b1);
      endcase
      SEQ_S2J: case (idx)
        3'd0:    seg = mk_seg(RUN_HI,   CW_S2J, 56, 1'b0);
        3'd1:    seg = mk_seg(RUN_CODE, CW_S2J, 16, 1'b0);
        default: seg = mk_seg(RUN_HI,   CW_S2J, 8,  1'b1);
      endcase
      SEQ_S2D: case (idx)
        3'd0:    seg = mk_seg(RUN_HI,   CW_S2D, 56, 1'b0);
        default: seg = mk_seg(RUN_CODE, CW_S2D, 16, 1'b1);
      endcase
      SEQ_D2S: case (idx)
        3'd0:    seg = mk_seg(RUN_HI,   CW_ALERT, 8,   1'b0);
        3'd1:    seg = mk_seg(RUN_CODE, CW_ALERT, 128, 1'b0);
        3'd2:    seg = mk_seg(RUN_LO,   CW_ALERT, 4,   1'b0);
        3'd3:    seg = mk_seg(RUN_CODE, CW_ACT,   8,   1'b0);
        3'd4:    seg = mk_seg(RUN_HI,   CW_ACT,   12,  1'b0);
        3'd5:    seg = mk_seg(RUN_HI,   CW_ACT,   56,  1'b0);
        default: seg = mk_seg(RUN_LO,   CW_ACT,   8,   1'b1);
      endcase
      SEQ_J2D: case (idx)
        3'd0:    seg = mk_seg(RUN_HI,   CW_J2D, 9,  1'b0);
        default: seg = mk_seg(RUN_CODE, CW_J2D, 31, 1'b1);
      endcase
      SEQ_D2J: case (idx)
        3'd0:    seg = mk_seg(RUN_HI,   CW_ALERT, 8,   1'b0);
        3'd1:    seg = mk_seg(RUN_CODE, CW_ALERT, 128, 1'b0);
        default: seg = mk_seg(RUN_LO,   CW_ALERT, 24,  1'b1);
      endcase
      default: seg = mk_seg(RUN_LO, CW_J2S, 1, 1'b1);
    endcase
  end

endmodule

// File: rtl/dlsw_bit_pick.sv
module dlsw_bit_pick
  import dlsw_pkg::*;
(
  input  run_e             kind,
  input  code_e            code,
  input  logic [LEN_W-1:0] pos,
  output logic             bit_o
);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    unique case (code)
      CW_J2S:   word = WORD_W'(WORD_J2S);
      CW_S2J:   word = WORD_W'(WORD_S2J);
      CW_S2D:   word = WORD_W'(WORD_S2D);
      CW_ALERT: word = WORD_ALERT;
      CW_ACT:   word = WORD_W'(WORD_ACT);
      CW_J2D:   word = WORD_W'(WORD_J2D);
      default:  word = '0;
    endcase
    shifted = word >> pos;
    unique case (kind)
      RUN_HI:   bit_o = 1'b1;
      RUN_CODE: bit_o = shifted[0];
      default:  bit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dlsw_gen.sv
module dlsw_gen
  import dlsw_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [2:0] pick,
  output logic       busy,
  output logic       done,
  output logic       line_oe,
  output logic       line_out
);

  seq_e             seq_q, seq_n;
  logic [SEG_W-1:0] idx_q, idx_n;
  logic [LEN_W-1:0] pos_q, pos_n, pos_inc;
  logic [LEN_W-1:0] len_q;
  logic             last_q;
  logic             busy_q, done_q, oe_q, line_q;
  seg_t             seg_n;
  logic             bit_n;
  logic             accept, seg_end, finish;

  assign accept  = !busy_q && go && (pick != 3'(SEQ_NONE));
  assign pos_inc = pos_q + LEN_W'(1);
  assign seg_end = (pos_inc == len_q);
  assign finish  = busy_q && seg_end && last_q;

  // Position of the bit to drive after the coming edge
  always_comb begin
    seq_n = seq_q;
    idx_n = idx_q;
    pos_n = pos_inc;
    if (accept) begin
      seq_n = seq_e'(pick);
      idx_n = '0;
      pos_n = '0;
    end else if (seg_end) begin
      idx_n = idx_q + SEG_W'(1);
      pos_n = '0;
    end
  end

  dlsw_seg_table u_table (
    .seq (seq_n),
    .idx (idx_n),
    .seg (seg_n)
  );

  dlsw_bit_pick u_pick (
    .kind  (seg_n.kind),
    .code  (seg_n.code),
    .pos   (pos_n),
    .bit_o (bit_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q  <= SEQ_LINE_RST;
      idx_q  <= '0;
      pos_q  <= '0;
      len_q  <= LEN_W'(1);
      last_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      oe_q   <= 1'b0;
      line_q <= IDLE_LVL;
    end else begin
      done_q <= finish;
      if (accept || (busy_q && !finish)) begin
        seq_q  <= seq_n;
        idx_q  <= idx_n;
        pos_q  <= pos_n;
        len_q  <= seg_n.len;
        last_q <= seg_n.last;
        busy_q <= 1'b1;
        oe_q   <= 1'b1;
        line_q <= bit_n;
      end else if (finish) begin
        busy_q <= 1'b0;
        oe_q   <= 1'b0;
        line_q <= IDLE_LVL;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign line_oe  = oe_q;
  assign line_out = line_q;

endmodule

// File: rtl/dlsw_gen_chk.sv
module dlsw_gen_chk #(
  parameter logic IDLE_LVL = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       go,
  input logic [2:0] pick,
  input logic       busy,
  input logic       done,
  input logic       line_oe,
  input logic       line_out
);

  logic [8:0] cnt;
  logic [8:0] exp_len;

  function automatic logic [8:0] len_of(logic [2:0] p);
    case (p)
      3'd0:    return 9'd64;
      3'd1:    return 9'd136;
      3'd2:    return 9'd80;
      3'd3:    return 9'd72;
      3'd4:    return 9'd224;
      3'd5:    return 9'd40;
      default: return 9'd160;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      exp_len <= '0;
    end else begin
      cnt <= busy ? cnt + 9'd1 : 9'd0;
      if (!busy && go && pick != 3'd7) exp_len <= len_of(pick);
    end
  end

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && go && pick != 3'd7) |=> (busy && line_oe)); // R1

  AST_LEN_EXACT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cnt == exp_len)); // R9

  AST_OE_DURING_RUN: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> line_oe); // R9

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !line_oe)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!line_oe && line_out == IDLE_LVL)); // R10

  AST_BAD_PICK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && go && pick == 3'd7) |=> !busy); // R11

endmodule

bind dlsw_gen dlsw_gen_chk #(.IDLE_LVL(IDLE_LVL)) u_dlsw_gen_chk (
  .clk      (clk),
  .rst      (rst),
  .go       (go),
  .pick     (pick),
  .busy     (busy),
  .done     (done),
  .line_oe  (line_oe),
  .line_out (line_out)
);

// File: tb/test_dlsw_gen.sv
module test_dlsw_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go = 1'b0;
  logic [2:0] pick = 3'd0;
  logic       busy, done, line_oe, line_out;

  int n_chk = 0;
  int n_bad = 0;
  logic ex [256];
  int   elen;

  localparam logic [7:0] ALERT_B [16] = '{
    8'h92, 8'hF3, 8'h09, 8'h62, 8'h95, 8'h2D, 8'h85, 8'h86,
    8'hE9, 8'hAF, 8'hDD, 8'hE3, 8'hA2, 8'h0E, 8'hBC, 8'h19};

  always #10 clk = ~clk;  // 50 MHz

  dlsw_gen #(.IDLE_LVL(1'b0)) i_dlsw_gen (
    .clk(clk), .rst(rst), .go(go), .pick(pick),
    .busy(busy), .done(done), .line_oe(line_oe), .line_out(line_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic add_run(input logic v, input int n);
    for (int i = 0; i < n; i++) begin ex[elen] = v; elen++; end
  endtask

  task automatic add_word(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin ex[elen] = w[i]; elen++; end
  endtask

  task automatic add_alert();
    for (int b = 0; b < 16; b++) add_word({24'd0, ALERT_B[b]}, 8);
  endtask

  task automatic build(input int s);
    elen = 0;
    case (s)
      0: begin add_run(1, 56); add_run(0, 8); end
      1: begin add_run(1, 56); add_word(32'hE79E, 16); add_run(1, 56); add_run(0, 8); end
      2: begin add_run(1, 56); add_word(32'hE73C, 16); add_run(1, 8); end
      3: begin add_run(1, 56); add_word(32'hE3BC, 16); end
      4: begin add_run(1, 8); add_alert(); add_run(0, 4); add_word(32'h1A, 8);
               add_run(1, 12); add_run(1, 56); add_run(0, 8); end
      5: begin add_run(1, 9); add_word(32'h33BBBBBA, 31); end
      default: begin add_run(1, 8); add_alert(); add_run(0, 24); end
    endcase
  endtask

  // Called at a negedge, one edge before the first bit shows
  task automatic launch(input int s);
    pick = 3'(s);
    go   = 1'b1;
    @(negedge clk);
    go   = 1'b0;
  endtask

  // Entered at the negedge where bit 0 is visible
  task automatic run_body(input int s, input bit poke, input int nxt);
    int bad_bit = -1;
    int bad_run = -1;
    build(s);
    for (int i = 0; i < elen; i++) begin
      if (line_out !== ex[i] && bad_bit < 0) bad_bit = i;
      if ((busy !== 1'b1 || line_oe !== 1'b1) && bad_run < 0) bad_run = i;
      if (poke && i == 10) begin pick = 3'd0; go = 1'b1; end
      if (poke && i == 12) go = 1'b0;
      @(negedge clk);
    end
    check(bad_bit < 0, tag_of(s), "first wrong bit index", bad_bit, -1);
    check(bad_run < 0, "R9", "busy/oe dropped at bit", bad_run, -1);
    check(done === 1'b1 && busy === 1'b0 && line_oe === 1'b0 && line_out === 1'b0,
          "R10", "done/busy/oe/line after last bit",
          {done, busy, line_oe, line_out}, 4'b1000);
    if (nxt >= 0) begin pick = 3'(nxt); go = 1'b1; end
    @(negedge clk);
    check(done === 1'b0, "R10", "done width", done, 0);
    if (nxt >= 0) begin
      go = 1'b0;
      check(busy === 1'b1 && line_oe === 1'b1 && line_out === 1'b1,
            "R12", "back-to-back start", {busy, line_oe, line_out}, 3'b111);
    end
  endtask

  task automatic t_reset();
    check(busy === 0 && done === 0 && line_oe === 0 && line_out === 0,
          "R13", "reset state", {busy, done, line_oe, line_out}, 0);
  endtask

  task automatic t_all_patterns();
    for (int s = 0; s < 7; s++) begin
      launch(s);
      check(busy === 1'b1 && line_oe === 1'b1, "R1", "accepted",
            {busy, line_oe}, 2'b11);
      run_body(s, 1'b0, -1);
    end
  endtask

  task automatic t_go_while_busy();
    launch(5);
    run_body(5, 1'b1, -1);
  endtask

  task automatic t_back_to_back();
    launch(3);
    run_body(3, 1'b0, 1);
    run_body(1, 1'b0, -1);
  endtask

  task automatic t_bad_pick();
    launch(7);
    check(busy === 1'b0 && line_oe === 1'b0, "R11", "reserved pick started",
          {busy, line_oe}, 0);
    @(negedge clk);
    check(busy === 1'b0 && line_oe === 1'b0 && line_out === 1'b0, "R11",
          "reserved pick later", {busy, line_oe, line_out}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_patterns();
    t_go_while_busy();
    t_back_to_back();
    t_bad_pick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule